// File: doc/BRIEF.md
# Oscillator Mode Selector and PLL Lock Sequencer

This block turns a static 3-bit oscillator configuration code into the control signals that the clock generation logic needs. It selects the system clock source (primary input, the ×4 output of an external PLL macro, or a slow secondary oscillator). It enables or disables the PLL macro and the crystal feedback driver. It also sets the role of the auxiliary oscillator pin, which can carry a divided-by-4 clock or serve as general-purpose I/O. The analog parts (phase comparator, loop filter, VCO, crystal amplifier) sit outside and are seen here only as clock and enable signals.

The PLL enable is held in a latch. It is refreshed only at power-on reset, or on the first primary-clock edge after the clock source returns from the secondary oscillator. The block holds a single `run_enable` output low while any delay still applies: the lock wait after the PLL is enabled, and the start-up wait that external-clock modes need after reset or wake. Both delays are parameters counted in primary-clock cycles. A sleep request freezes every counter and keeps the latched PLL enable.

Top module: `clk_mode_seq`

## Requirements
- R1: Configuration codes are 0 low-power crystal, 1 crystal, 2 fast crystal, 3 RC, 4 external clock with clock-out, 5 external clock with I/O, 6 fast crystal with ×4 PLL, 7 reserved. The reserved code behaves as a plain primary-oscillator mode: feedback on, PLL off, auxiliary pin neither clock-out nor I/O, and no delay.
- R2: In code 4, `aux_pin_clkout_en` is 1 and `aux_pin_clkout` is the primary clock divided by CLKOUT_DIV. It comes from a counter cleared by reset, so with the default of 4 the output is low after the first edge following reset release, high after edges 2 and 3, and repeats with a period of 4 edges. In every other code `aux_pin_clkout` is 0.
- R3: In code 5, `aux_pin_gpio_en` is 1 (the pin is handed to general-purpose I/O as port A bit 6) and `aux_pin_clkout_en` is 0. The two pin enables are never high together.
- R4: `fb_en` is 0 in codes 4 and 5 and 1 in every other code.
- R5: `clk_sel` encodes 0 = primary, 1 = PLL, 2 = secondary. It is 2 while `use_sec` is 1, otherwise 1 when `pll_en` is 1, otherwise 0. `sys_clk` follows the selected clock input. `pll_en` can be 1 only when the latched code was 6.
- R6: `pll_en` is loaded from the configuration on the first edge after reset release on which `use_sec` is 0. It is loaded again on the first edge with `use_sec` 0 that follows at least one edge with `use_sec` 1. Configuration changes at any other time have no effect on it.
- R7: Each load that sets `pll_en` to 1 holds `run_enable` low for LOCK_CYCLES edges after the load edge.
- R8: In codes 4 and 5, `run_enable` stays low for STARTUP_CYCLES edges after the first edge following reset release, and the same wait applies again after wake.
- R9: While `sleep_req` is 1, `run_enable` is 0, all counters (divider and both delays) hold their values, and `pll_en` is kept. The edge on which `sleep_req` is first seen low again restarts the start-up wait in codes 4 and 5.
- R10: `run_enable` is 1 only when no delay is pending. In codes with no delay it rises after the first edge following reset release or wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri | input | 1 | Primary oscillator clock; also clocks this block |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| osc_cfg | input | 3 | Oscillator configuration code |
| use_sec | input | 1 | Request to run from the secondary oscillator |
| sleep_req | input | 1 | Sleep request; freezes counters |
| clk_pll | input | 1 | ×4 clock from the PLL macro |
| clk_sec | input | 1 | Secondary low-speed oscillator clock |
| sys_clk | output | 1 | Selected system clock |
| clk_sel | output | 2 | Source code: 0 primary, 1 PLL, 2 secondary |
| pll_en | output | 1 | Latched enable to the PLL macro |
| fb_en | output | 1 | Crystal feedback driver enable |
| aux_pin_clkout_en | output | 1 | Auxiliary pin drives the divided clock |
| aux_pin_clkout | output | 1 | Divided clock for the auxiliary pin |
| aux_pin_gpio_en | output | 1 | Auxiliary pin released to general-purpose I/O |
| run_enable | output | 1 | Execution allowed; all delays expired |

## Verification
The bench builds the block with LOCK_CYCLES = 20, STARTUP_CYCLES = 6 and CLKOUT_DIV = 4. Because the two delays differ, the measured edge count to `run_enable` shows which wait was applied. That separates a lock wait, a start-up wait and no wait, both after reset and after wake, and it exposes an off-by-one in either counter. Short windows also let the latch scenario cross the secondary source twice and watch a fresh lock wait complete.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;

   typedef enum logic [2:0] {
      MODE_LOWPWR_XTAL  = 3'd0,
      MODE_XTAL         = 3'd1,
      MODE_FAST_XTAL    = 3'd2,
      MODE_RC           = 3'd3,
      MODE_EXTCLK_OUT   = 3'd4,
      MODE_EXTCLK_IO    = 3'd5,
      MODE_FAST_XTAL_X4 = 3'd6,
      MODE_RESERVED     = 3'd7
   } osc_mode_e;

   typedef enum logic [1:0] {
      SRC_PRI = 2'd0,
      SRC_PLL = 2'd1,
      SRC_SEC = 2'd2
   } clk_src_e;

   typedef struct packed {
      logic ext_clk;      // start-up wait applies
      logic pin_clkout;   // auxiliary pin carries divided clock
      logic pin_gpio;     // auxiliary pin released to I/O
      logic fb_on;        // crystal feedback driver on
      logic pll_allowed;  // PLL may be latched on
   } mode_ctl_t;

endpackage

// File: rtl/clk_mode_decode.sv
module clk_mode_decode
   import clk_mode_pkg::*;
(
   input  logic [2:0] cfg,
   output mode_ctl_t  ctl
);

   always_comb begin
      ctl = '0;
      ctl.fb_on = 1'b1;
      case (osc_mode_e'(cfg))
         MODE_EXTCLK_OUT: begin
            ctl.ext_clk    = 1'b1;
            ctl.pin_clkout = 1'b1;
            ctl.fb_on      = 1'b0;
         end
         MODE_EXTCLK_IO: begin
            ctl.ext_clk  = 1'b1;
            ctl.pin_gpio = 1'b1;
            ctl.fb_on    = 1'b0;
         end
         MODE_FAST_XTAL_X4: ctl.pll_allowed = 1'b1;
         default: ctl.fb_on = 1'b1;
      endcase
   end

endmodule

// File: rtl/clk_hold_timer.sv
module clk_hold_timer #(
   parameter int LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic freeze,
   output logic busy
);

   localparam int W = $clog2(LEN + 1);
   localparam logic [W-1:0] LOAD = W'(LEN);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (start)
         cnt <= LOAD;
      else if (!freeze && cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

endmodule

// File: rtl/clk_aux_div.sv
module clk_aux_div #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic freeze,
   output logic div_out
);

   localparam int W = (DIV > 2) ? $clog2(DIV) : 1;

   logic [W-1:0] phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (!freeze)
         phase <= phase + 1'b1;
   end

   assign div_out = phase[W-1];

endmodule

// File: rtl/clk_mode_seq.sv
module clk_mode_seq
   import clk_mode_pkg::*;
#(
   parameter int LOCK_CYCLES    = 2048,
   parameter int STARTUP_CYCLES = 15,
   parameter int CLKOUT_DIV     = 4
) (
   input  logic       clk_pri,
   input  logic       por_n,
   input  logic [2:0] osc_cfg,
   input  logic       use_sec,
   input  logic       sleep_req,
   input  logic       clk_pll,
   input  logic       clk_sec,
   output logic       sys_clk,
   output logic [1:0] clk_sel,
   output logic       pll_en,
   output logic       fb_en,
   output logic       aux_pin_clkout_en,
   output logic       aux_pin_clkout,
   output logic       aux_pin_gpio_en,
   output logic       run_enable
);

   generate
      if (LOCK_CYCLES < 1) begin : g_bad_lock
         $error("LOCK_CYCLES must be at least 1");
      end
      if (STARTUP_CYCLES < 1) begin : g_bad_startup
         $error("STARTUP_CYCLES must be at least 1");
      end
      if (CLKOUT_DIV < 2 || (CLKOUT_DIV & (CLKOUT_DIV - 1)) != 0) begin : g_bad_div
         $error("CLKOUT_DIV must be a power of two of at least 2");
      end
   endgenerate

   mode_ctl_t ctl;
   clk_src_e  src;
   logic      boot_q, arm_q, pll_q, sleep_q;
   logic      load, lock_start, su_start;
   logic      lock_busy, su_busy, div_out;

   clk_mode_decode u_decode (
      .cfg (osc_cfg),
      .ctl (ctl)
   );

   // PLL enable latch: refreshed only after reset or a return from the secondary source
   assign load = arm_q && !use_sec;

   always_ff @(posedge clk_pri or negedge por_n) begin
      if (!por_n) begin
         boot_q  <= 1'b1;
         arm_q   <= 1'b1;
         pll_q   <= 1'b0;
         sleep_q <= 1'b0;
      end else begin
         boot_q  <= 1'b0;
         sleep_q <= sleep_req;
         if (use_sec)
            arm_q <= 1'b1;
         else if (arm_q) begin
            arm_q <= 1'b0;
            pll_q <= ctl.pll_allowed;
         end
      end
   end

   assign lock_start = load && ctl.pll_allowed;
   assign su_start   = ctl.ext_clk && (boot_q || (sleep_q && !sleep_req));

   clk_hold_timer #(.LEN(LOCK_CYCLES)) u_lock_timer (
      .clk    (clk_pri),
      .rst_n  (por_n),
      .start  (lock_start),
      .freeze (sleep_req),
      .busy   (lock_busy)
   );

   clk_hold_timer #(.LEN(STARTUP_CYCLES)) u_startup_timer (
      .clk    (clk_pri),
      .rst_n  (por_n),
      .start  (su_start),
      .freeze (sleep_req),
      .busy   (su_busy)
   );

   clk_aux_div #(.DIV(CLKOUT_DIV)) u_aux_div (
      .clk     (clk_pri),
      .rst_n   (por_n),
      .freeze  (sleep_req),
      .div_out (div_out)
   );

   always_comb begin
      if (use_sec)
         src = SRC_SEC;
      else if (pll_q)
         src = SRC_PLL;
      else
         src = SRC_PRI;
   end

   always_comb begin
      case (src)
         SRC_SEC: sys_clk = clk_sec;
         SRC_PLL: sys_clk = clk_pll;
         default: sys_clk = clk_pri;
      endcase
   end

   assign clk_sel           = src;
   assign pll_en            = pll_q;
   assign fb_en             = ctl.fb_on;
   assign aux_pin_clkout_en = ctl.pin_clkout;
   assign aux_pin_clkout    = ctl.pin_clkout & div_out;
   assign aux_pin_gpio_en   = ctl.pin_gpio;
   assign run_enable        = !boot_q && !sleep_req && !sleep_q && !su_busy && !lock_busy;

endmodule

// File: rtl/clk_mode_seq_chk.sv
module clk_mode_seq_chk (
   input logic       clk_pri,
   input logic       por_n,
   input logic       use_sec,
   input logic       sleep_req,
   input logic [1:0] clk_sel,
   input logic       pll_en,
   input logic       fb_en,
   input logic       aux_pin_clkout_en,
   input logic       aux_pin_clkout,
   input logic       aux_pin_gpio_en,
   input logic       run_enable
);

   logic [1:0] edges;

   always_ff @(posedge clk_pri or negedge por_n) begin
      if (!por_n)
         edges <= 2'd0;
      else if (edges != 2'd3)
         edges <= edges + 2'd1;
   end

   assert_pll_en_held_R6: assert property (@(posedge clk_pri) disable iff (!por_n)
      (edges == 2'd3 && !use_sec && $past(!use_sec) && $past(!use_sec, 2)) |-> $stable(pll_en));

   assert_lock_gates_run_R7: assert property (@(posedge clk_pri) disable iff (!por_n)
      $rose(pll_en) |-> !run_enable);

   assert_wake_gated_R9: assert property (@(posedge clk_pri) disable iff (!por_n)
      $fell(sleep_req) |-> !run_enable);

   assert_clkout_high_two_R2: assert property (@(posedge clk_pri) disable iff (!por_n)
      $rose(aux_pin_clkout) |=> (aux_pin_clkout || !aux_pin_clkout_en));

   assert_pin_exclusive_R3: assert property (@(posedge clk_pri) disable iff (!por_n)
      !(aux_pin_clkout_en && aux_pin_gpio_en));

   assert_clkout_quiet_R2: assert property (@(posedge clk_pri) disable iff (!por_n)
      !aux_pin_clkout_en |-> !aux_pin_clkout);

   assert_fb_off_R4: assert property (@(posedge clk_pri) disable iff (!por_n)
      (aux_pin_clkout_en || aux_pin_gpio_en) |-> !fb_en);

   assert_pll_path_R5: assert property (@(posedge clk_pri) disable iff (!por_n)
      (clk_sel == 2'd1) |-> pll_en);

endmodule

bind clk_mode_seq clk_mode_seq_chk u_chk (.*);

// File: tb/clk_mode_seq_test.sv
module clk_mode_seq_test;

   localparam int LOCK = 20;
   localparam int SU   = 6;

   logic       clk_pri = 1'b0;
   logic       por_n = 1'b0;
   logic [2:0] osc_cfg = 3'd4;
   logic       use_sec = 1'b0;
   logic       sleep_req = 1'b0;
   logic       clk_pll = 1'b1;
   logic       clk_sec = 1'b0;
   logic       sys_clk, pll_en, fb_en, aux_pin_clkout_en, aux_pin_clkout, aux_pin_gpio_en, run_enable;
   logic [1:0] clk_sel;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk_pri = ~clk_pri;

   clk_mode_seq #(.LOCK_CYCLES(LOCK), .STARTUP_CYCLES(SU), .CLKOUT_DIV(4)) uut (
      .clk_pri(clk_pri), .por_n(por_n), .osc_cfg(osc_cfg), .use_sec(use_sec),
      .sleep_req(sleep_req), .clk_pll(clk_pll), .clk_sec(clk_sec), .sys_clk(sys_clk),
      .clk_sel(clk_sel), .pll_en(pll_en), .fb_en(fb_en),
      .aux_pin_clkout_en(aux_pin_clkout_en), .aux_pin_clkout(aux_pin_clkout),
      .aux_pin_gpio_en(aux_pin_gpio_en), .run_enable(run_enable)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   task automatic do_reset(input logic [2:0] cfg);
      @(negedge clk_pri);
      por_n = 1'b0; osc_cfg = cfg; use_sec = 1'b0; sleep_req = 1'b0;
      repeat (2) @(negedge clk_pri);
      por_n = 1'b1;
   endtask

   // counts edges until run_enable is seen high at a falling edge
   task automatic wait_run(output int n);
      n = 0;
      do begin
         @(posedge clk_pri);
         n++;
         @(negedge clk_pri);
      end while (!run_enable && n < 200);
   endtask

   task automatic t_reset_state();
      @(negedge clk_pri);
      por_n = 1'b0; osc_cfg = 3'd4;
      repeat (2) @(negedge clk_pri);
      chk("R10", "run_enable in reset", run_enable, 0);
      chk("R5", "pll_en in reset", pll_en, 0);
      chk("R2", "clkout in reset", aux_pin_clkout, 0);
      chk("R5", "clk_sel in reset", clk_sel, 0);
   endtask

   task automatic t_clkout_div();
      int n;
      do_reset(3'd4);
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk_pri);
         chk("R2", $sformatf("clkout after edge %0d", k), aux_pin_clkout, ((k % 4) >= 2) ? 1 : 0);
      end
      chk("R2", "clkout enable", aux_pin_clkout_en, 1);
      chk("R3", "gpio enable in clock-out mode", aux_pin_gpio_en, 0);
      chk("R4", "feedback in clock-out mode", fb_en, 0);
      do_reset(3'd4);
      wait_run(n);
      chk("R8", "edges to run, clock-out mode", n, 1 + SU);
   endtask

   task automatic t_gpio_mode();
      int n;
      do_reset(3'd5);
      wait_run(n);
      chk("R8", "edges to run, I/O mode", n, 1 + SU);
      chk("R3", "gpio enable", aux_pin_gpio_en, 1);
      chk("R3", "clkout enable in I/O mode", aux_pin_clkout_en, 0);
      repeat (3) @(negedge clk_pri);
      chk("R3", "clkout quiet in I/O mode", aux_pin_clkout, 0);
      chk("R4", "feedback in I/O mode", fb_en, 0);
   endtask

   task automatic t_pll_boot();
      int n;
      do_reset(3'd6);
      wait_run(n);
      chk("R7", "edges to run after lock", n, 1 + LOCK);
      chk("R5", "pll_en with PLL code", pll_en, 1);
      chk("R5", "clk_sel on PLL", clk_sel, 1);
      chk("R5", "sys_clk follows PLL", sys_clk, clk_pll);
      chk("R4", "feedback with PLL code", fb_en, 1);
   endtask

   task automatic t_pll_latch();
      int n;
      osc_cfg = 3'd2;
      repeat (5) @(negedge clk_pri);
      chk("R6", "pll_en kept after code change on primary", pll_en, 1);
      use_sec = 1'b1;
      #1;
      chk("R5", "clk_sel on secondary", clk_sel, 2);
      chk("R5", "sys_clk follows secondary", sys_clk, clk_sec);
      repeat (2) @(negedge clk_pri);
      chk("R6", "pll_en kept while on secondary", pll_en, 1);
      use_sec = 1'b0;
      @(negedge clk_pri);
      chk("R6", "pll_en reloaded off on return", pll_en, 0);
      chk("R5", "clk_sel primary", clk_sel, 0);
      chk("R5", "sys_clk follows primary", sys_clk, clk_pri);
      chk("R10", "run with no lock pending", run_enable, 1);
      osc_cfg = 3'd6;
      repeat (5) @(negedge clk_pri);
      chk("R6", "pll_en ignores code change on primary", pll_en, 0);
      use_sec = 1'b1;
      repeat (2) @(negedge clk_pri);
      use_sec = 1'b0;
      wait_run(n);
      chk("R7", "edges to run after relock", n, 1 + LOCK);
      chk("R6", "pll_en reloaded on", pll_en, 1);
   endtask

   task automatic t_sleep_extclk();
      int n;
      logic held;
      do_reset(3'd4);
      wait_run(n);
      sleep_req = 1'b1;
      #1;
      chk("R9", "run_enable in sleep", run_enable, 0);
      held = aux_pin_clkout;
      repeat (3) @(negedge clk_pri);
      chk("R9", "divider frozen in sleep", aux_pin_clkout, held);
      sleep_req = 1'b0;
      wait_run(n);
      chk("R9", "edges to run after wake, clock-out mode", n, 1 + SU);
   endtask

   task automatic t_sleep_pll();
      int n;
      do_reset(3'd6);
      wait_run(n);
      sleep_req = 1'b1;
      repeat (4) @(negedge clk_pri);
      chk("R9", "pll_en kept in sleep", pll_en, 1);
      sleep_req = 1'b0;
      wait_run(n);
      chk("R10", "edges to run after wake, PLL code", n, 1);
      chk("R9", "pll_en kept after wake", pll_en, 1);
   endtask

   task automatic t_plain(input logic [2:0] cfg, input string req);
      int n;
      do_reset(cfg);
      wait_run(n);
      chk(req, $sformatf("edges to run, code %0d", cfg), n, 1);
      chk(req, $sformatf("feedback, code %0d", cfg), fb_en, 1);
      chk(req, $sformatf("pin enables, code %0d", cfg), {aux_pin_clkout_en, aux_pin_gpio_en}, 0);
      chk(req, $sformatf("pll_en, code %0d", cfg), pll_en, 0);
   endtask

   initial begin
      t_reset_state();
      t_clkout_div();
      t_gpio_mode();
      t_pll_boot();
      t_pll_latch();
      t_sleep_extclk();
      t_sleep_pll();
      t_plain(3'd2, "R10");
      t_plain(3'd7, "R1");
      t_plain(3'd0, "R1");
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule